// File: doc/BRIEF.md
# Synchronous Flow-Through Burst Static RAM

This block is a synthesizable static RAM whose every address, select, strobe, write-enable and write-data input is sampled on the rising clock edge. The data word is made of byte lanes. The lane width, the lane count and the address width are all parameters. A transaction opens on one of two load strobes. Within the aligned group of four words, later beats take their addresses from a two-bit beat counter. The `step_n` input moves that counter forward. The level on `ilv_mode` sets the beat order: linear (add modulo 4) or interleaved (XOR). Throughout a burst, the address bits above the low two never change.

Reads are flow-through. Once an edge has loaded or advanced the address, that word appears on `rdata` within the same cycle, with no output register in the path. The output enable is asynchronous. The block has no bidirectional pin. In place of one, `rdata_drv` tells when the bus would be driven, and `rdata` reads zero whenever `rdata_drv` is low. Writes happen at the same edge that samples the write data, and each write can touch all lanes or only some of them. Several of these blocks can share one read bus for depth expansion, because a deselect releases the bus one edge after it is sampled. A sleep input freezes every register and the memory contents.

The interface is plain. It has no valid/ready handshake and no back-pressure, because each access completes in the cycle in which it is sampled.

Top module: `burst_sram`

## Requirements
- R1: An edge with `ld_sec_n` low and the chip selected (`sel_n`=0, `sel_hi`=1, `sel_lo_n`=0) loads `addr` and resets the beat counter to 0. If write enables are active at that edge, `wdata` is written to `addr` at that same edge.
- R2: An edge with `ld_pri_n` low and `sel_n` low loads `addr` and opens a read, even when write enables are asserted, and nothing is written. This strobe takes priority over `ld_sec_n` when both are low.
- R3: `ld_pri_n` is ignored while `sel_n` is high. In that case the burst state and the read output stay unchanged.
- R4: In an open burst, an edge with neither strobe taken and `step_n` low advances the beat counter by one, wrapping modulo 4. With `step_n` high, the counter holds its address. Continuation writes go to the address that is current after that edge.
- R5: When `ilv_mode`=0 (linear), the address of beat k has low two bits equal to (start + k) mod 4, and the upper bits stay fixed.
- R6: When `ilv_mode`=1 (interleaved), the address of beat k has low two bits equal to start XOR k, and the upper bits stay fixed.
- R7: With `wr_all_n` low, every lane of the addressed word is written, whatever `lane_wr_n` and `lane_en_gate_n` are.
- R8: With `wr_all_n` high, lane i (bits [i*LANE_W +: LANE_W]) is written exactly when `lane_en_gate_n` is low and `lane_wr_n[i]` is low. With `lane_en_gate_n` high, no lane is written.
- R9: Right after an edge that opens or continues a read, `rdata` holds the stored word at the current burst address and `rdata_drv` is 1, provided `out_en_n` is low and `sleep` is low. After a write edge, `rdata_drv` is 0.
- R10: While `out_en_n` is high, `rdata_drv` is 0 at once, with no clock edge needed.
- R11: A strobe edge taken while any chip select is inactive ends the burst. `rdata_drv` goes low right after that edge and not before it, and a later `step_n` does not bring it back.
- R12: While `sleep` is high, `rdata_drv` is 0, no write takes place and no register changes. When `sleep` drops, the earlier read is back on the output.
- R13: After reset, no burst is open and `rdata_drv` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control registers |
| addr | input | ADDR_W | Word address, taken by a load strobe |
| sel_n | input | 1 | Primary chip select, active low; also gates `ld_pri_n` |
| sel_hi | input | 1 | Depth-expansion select, active high |
| sel_lo_n | input | 1 | Depth-expansion select, active low |
| ld_pri_n | input | 1 | Priority load strobe, always opens a read |
| ld_sec_n | input | 1 | Secondary load strobe, opens a read or a write |
| step_n | input | 1 | Burst advance, active low |
| lane_en_gate_n | input | 1 | Gate for the per-lane write enables, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| wr_all_n | input | 1 | Whole-word write, active low |
| wdata | input | LANES*LANE_W | Write data |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| ilv_mode | input | 1 | Static burst order: 0 linear, 1 interleaved |
| sleep | input | 1 | Freezes the block and releases the output |
| rdata | output | LANES*LANE_W | Flow-through read data, zero when not driven |
| rdata_drv | output | 1 | High when the read bus is driven |

## Verification
When a base or beat register is wrong, the problem shows in the very cycle after the faulty edge: `rdata` carries a word from the wrong position in the group. Each burst is therefore checked beat by beat against a model array, in both orders and from start offsets that are not zero. If the state that records read versus write, or selected versus deselected, is wrong, `rdata_drv` shows it right after the strobe edge. The bench checks that signal on both sides of a deselect edge. A wrong write mask does not show until the word is read back, so every masked write is followed by a read of the same address.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int BEAT_W = 2;

  typedef enum logic {
    ORDER_LINEAR      = 1'b0,
    ORDER_INTERLEAVED = 1'b1
  } burst_order_e;

  function automatic logic [BEAT_W-1:0] beat_offset(
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] beat,
    input burst_order_e      order
  );
    if (order == ORDER_INTERLEAVED) return start ^ beat;
    return start + beat;
  endfunction
endpackage

// File: rtl/sram_burst_seq.sv
module sram_burst_seq
  import sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [BEAT_W-1:0] beat,
  input  logic              interleave,
  output logic [ADDR_W-1:0] addr
);
  burst_order_e order;
  assign order = interleave ? ORDER_INTERLEAVED : ORDER_LINEAR;

  // upper bits fixed, low bits reordered
  assign addr = {base[ADDR_W-1:BEAT_W], beat_offset(base[BEAT_W-1:0], beat, order)};
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sel_n,
  input  logic              sel_hi,
  input  logic              sel_lo_n,
  input  logic              ld_pri_n,
  input  logic              ld_sec_n,
  input  logic              step_n,
  input  logic              lane_en_gate_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic              wr_all_n,
  input  logic              ilv_mode,
  input  logic              sleep,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [LANES-1:0]  lane_we,
  output logic              rd_live,
  output logic              burst_live,
  output logic [BEAT_W-1:0] beat
);
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q, beat_nxt;
  logic              live_q, read_q;
  logic              chip_on, take_pri, take_sec, load;
  logic [LANES-1:0]  lane_mask;
  logic              wr_req;
  logic [ADDR_W-1:0] addr_cur, addr_adv;

  assign chip_on  = !sel_n && sel_hi && !sel_lo_n;
  assign take_pri = !ld_pri_n && !sel_n;
  assign take_sec = !ld_sec_n && !take_pri;
  assign load     = take_pri || take_sec;
  assign beat_nxt = beat_q + 1'b1;

  always_comb begin
    if (!wr_all_n)            lane_mask = '1;
    else if (!lane_en_gate_n) lane_mask = ~lane_wr_n;
    else                      lane_mask = '0;
  end
  assign wr_req = |lane_mask;

  sram_burst_seq #(.ADDR_W(ADDR_W)) u_seq_cur (
    .base(base_q), .beat(beat_q), .interleave(ilv_mode), .addr(addr_cur)
  );
  sram_burst_seq #(.ADDR_W(ADDR_W)) u_seq_adv (
    .base(base_q), .beat(beat_nxt), .interleave(ilv_mode), .addr(addr_adv)
  );

  always_comb begin
    wr_addr = addr;
    lane_we = '0;
    if (!sleep) begin
      if (take_sec && chip_on) begin
        wr_addr = addr;
        lane_we = lane_mask;
      end else if (!load && live_q) begin
        wr_addr = step_n ? addr_cur : addr_adv;
        lane_we = lane_mask;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
      live_q <= 1'b0;
      read_q <= 1'b0;
    end else if (!sleep) begin
      if (load) begin
        base_q <= addr;
        beat_q <= '0;
        live_q <= chip_on;
        read_q <= take_pri ? 1'b1 : !wr_req;
      end else if (live_q) begin
        if (!step_n) beat_q <= beat_nxt;
        read_q <= !wr_req;
      end
    end
  end

  assign rd_addr    = addr_cur;
  assign rd_live    = live_q && read_q;
  assign burst_live = live_q;
  assign beat       = beat_q;
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sel_n,
  input  logic              sel_hi,
  input  logic              sel_lo_n,
  input  logic              ld_pri_n,
  input  logic              ld_sec_n,
  input  logic              step_n,
  input  logic              lane_en_gate_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic              wr_all_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic              out_en_n,
  input  logic              ilv_mode,
  input  logic              sleep,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_drv
);
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [LANES-1:0]  lane_we;
  logic              rd_live, burst_live;
  logic [BEAT_W-1:0] beat;
  logic [DATA_W-1:0] array_q;

  sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .sel_n(sel_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
    .ld_pri_n(ld_pri_n), .ld_sec_n(ld_sec_n), .step_n(step_n),
    .lane_en_gate_n(lane_en_gate_n), .lane_wr_n(lane_wr_n), .wr_all_n(wr_all_n),
    .ilv_mode(ilv_mode), .sleep(sleep),
    .rd_addr(rd_addr), .wr_addr(wr_addr), .lane_we(lane_we),
    .rd_live(rd_live), .burst_live(burst_live), .beat(beat)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    sram_lane_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
      .clk(clk),
      .we(lane_we[i]),
      .waddr(wr_addr),
      .wdata(wdata[i*LANE_W +: LANE_W]),
      .raddr(rd_addr),
      .rdata(array_q[i*LANE_W +: LANE_W])
    );
  end

  assign rdata_drv = rd_live && !out_en_n && !sleep;
  assign rdata     = rdata_drv ? array_q : '0;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_n,
  input logic             sel_hi,
  input logic             sel_lo_n,
  input logic             ld_pri_n,
  input logic             ld_sec_n,
  input logic             step_n,
  input logic             out_en_n,
  input logic             sleep,
  input logic             rdata_drv,
  input logic [LANES-1:0] lane_we,
  input logic             burst_live,
  input logic [1:0]       beat
);
  // R10
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !rdata_drv);

  // R12
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (!rdata_drv && lane_we == '0));

  // R12
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> ($stable(beat) && $stable(burst_live)));

  // R11
  deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && (!ld_sec_n || (!ld_pri_n && !sel_n)) && !(!sel_n && sel_hi && !sel_lo_n))
    |=> !rdata_drv);

  // R4
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && burst_live && ld_sec_n && (ld_pri_n || sel_n) && !step_n)
    |=> beat == $past(beat) + 2'd1);

  // R2
  pri_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !ld_pri_n && !sel_n) |-> lane_we == '0);
endmodule

bind burst_sram burst_sram_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
  .ld_pri_n(ld_pri_n), .ld_sec_n(ld_sec_n), .step_n(step_n), .out_en_n(out_en_n),
  .sleep(sleep), .rdata_drv(rdata_drv), .lane_we(lane_we),
  .burst_live(burst_live), .beat(beat)
);

// File: tb/burst_sram_test.sv
module burst_sram_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int LW = 9;
  localparam int DW = 2 * LW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic sel_n = 1'b0, sel_hi = 1'b1, sel_lo_n = 1'b0;
  logic ld_pri_n = 1'b1, ld_sec_n = 1'b1, step_n = 1'b1;
  logic lane_en_gate_n = 1'b1, wr_all_n = 1'b1;
  logic [1:0] lane_wr_n = 2'b11;
  logic [DW-1:0] wdata = '0;
  logic out_en_n = 1'b0, ilv_mode = 1'b0, sleep = 1'b0;
  logic [DW-1:0] rdata;
  logic rdata_drv;

  int checks = 0;
  int fails = 0;
  logic [DW-1:0] model [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_sram #(.ADDR_W(AW), .LANES(2), .LANE_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sel_n), .sel_hi(sel_hi),
    .sel_lo_n(sel_lo_n), .ld_pri_n(ld_pri_n), .ld_sec_n(ld_sec_n), .step_n(step_n),
    .lane_en_gate_n(lane_en_gate_n), .lane_wr_n(lane_wr_n), .wr_all_n(wr_all_n),
    .wdata(wdata), .out_en_n(out_en_n), .ilv_mode(ilv_mode), .sleep(sleep),
    .rdata(rdata), .rdata_drv(rdata_drv)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] b, input int k, input logic ilv);
    logic [1:0] kk = 2'(k);
    return {b[AW-1:2], ilv ? (b[1:0] ^ kk) : (b[1:0] + kk)};
  endfunction

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return DW'(a * 37 + salt * 1013 + 5);
  endfunction

  task automatic idle();
    ld_pri_n = 1'b1; ld_sec_n = 1'b1; step_n = 1'b1;
    sel_n = 1'b0; sel_hi = 1'b1; sel_lo_n = 1'b0;
    lane_en_gate_n = 1'b1; lane_wr_n = 2'b11; wr_all_n = 1'b1;
    out_en_n = 1'b0; sleep = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_burst(input logic [AW-1:0] b, input logic ilv, input int salt);
    ilv_mode = ilv;
    for (int k = 0; k < 4; k++) begin
      idle();
      if (k == 0) begin ld_sec_n = 1'b0; addr = b; end
      else step_n = 1'b0;
      wr_all_n = 1'b0;
      wdata = pat(int'(beat_addr(b, k, ilv)), salt);
      tick();
      model[beat_addr(b, k, ilv)] = wdata;
      check("R9 write edge no drive", 32'(rdata_drv), 32'd0);
    end
    idle();
  endtask

  task automatic read_burst(input logic [AW-1:0] b, input logic ilv, input string req);
    ilv_mode = ilv;
    for (int k = 0; k < 4; k++) begin
      idle();
      if (k == 0) begin ld_pri_n = 1'b0; addr = b; end
      else step_n = 1'b0;
      tick();
      check(req, 32'(rdata_drv), 32'd1);
      check(req, 32'(rdata), 32'(model[beat_addr(b, k, ilv)]));
    end
    idle();
  endtask

  task automatic read_one(input logic [AW-1:0] a, input string req);
    idle(); ld_pri_n = 1'b0; addr = a;
    tick();
    check(req, 32'(rdata), 32'(model[a]));
    idle();
  endtask

  task automatic t_reset();
    check("R13 reset drive", 32'(rdata_drv), 32'd0);
    idle(); step_n = 1'b0; tick();
    check("R13 no burst after reset", 32'(rdata_drv), 32'd0);
    idle();
  endtask

  task automatic t_fill();
    for (int g = 0; g < 16; g++) write_burst(AW'(g * 4), 1'b0, 1);
    read_burst(6'd2, 1'b0, "R1 R5 linear from 2");
    read_burst(6'd13, 1'b1, "R6 interleaved from 1");
    write_burst(6'd23, 1'b1, 2);
    read_burst(6'd23, 1'b0, "R4 R6 interleaved write, linear read");
    read_burst(6'd23, 1'b1, "R6 interleaved from 3");
  endtask

  task automatic t_lanes();
    idle(); ld_sec_n = 1'b0; addr = 6'd10; lane_en_gate_n = 1'b0; lane_wr_n = 2'b10;
    wdata = 18'h2A5A5; tick();
    model[10][LW-1:0] = wdata[LW-1:0];
    read_one(6'd10, "R8 low lane only");
    idle(); ld_sec_n = 1'b0; addr = 6'd10; lane_en_gate_n = 1'b1; lane_wr_n = 2'b00;
    wdata = 18'h11111; tick();
    read_one(6'd10, "R8 gate high no write");
    idle(); ld_sec_n = 1'b0; addr = 6'd11; lane_en_gate_n = 1'b0; lane_wr_n = 2'b01;
    wdata = 18'h3C0F0; tick();
    model[11][DW-1:LW] = wdata[DW-1:LW];
    read_one(6'd11, "R8 high lane only");
    idle(); ld_sec_n = 1'b0; addr = 6'd12; wr_all_n = 1'b0; lane_en_gate_n = 1'b1;
    lane_wr_n = 2'b11; wdata = 18'h1F0E1; tick();
    model[12] = wdata;
    read_one(6'd12, "R7 whole word");
  endtask

  task automatic t_step_hold();
    ilv_mode = 1'b0;
    read_one(6'd20, "R4 start");
    idle(); step_n = 1'b1; tick();
    check("R4 hold", 32'(rdata), 32'(model[20]));
    idle(); step_n = 1'b0; tick();
    check("R4 advance", 32'(rdata), 32'(model[21]));
    idle();
  endtask

  task automatic t_priority();
    idle(); ld_pri_n = 1'b0; ld_sec_n = 1'b0; addr = 6'd30; wr_all_n = 1'b0;
    wdata = 18'h00BAD; tick();
    check("R2 reads", 32'(rdata_drv), 32'd1);
    check("R2 no write", 32'(rdata), 32'(model[30]));
    read_one(6'd30, "R2 content kept");
  endtask

  task automatic t_pri_ignored();
    read_one(6'd40, "R3 start");
    idle(); sel_n = 1'b1; ld_pri_n = 1'b0; addr = 6'd50; tick();
    check("R3 still driven", 32'(rdata_drv), 32'd1);
    check("R3 same word", 32'(rdata), 32'(model[40]));
    idle();
  endtask

  task automatic t_deselect();
    read_one(6'd41, "R11 start");
    idle(); ld_sec_n = 1'b0; sel_hi = 1'b0; addr = 6'd42;
    #1;
    check("R11 driven before edge", 32'(rdata_drv), 32'd1);
    tick();
    check("R11 released", 32'(rdata_drv), 32'd0);
    idle(); step_n = 1'b0; tick();
    check("R11 step no revive", 32'(rdata_drv), 32'd0);
    idle();
  endtask

  task automatic t_oe();
    read_one(6'd42, "R10 start");
    out_en_n = 1'b1; #1;
    check("R10 async off", 32'(rdata_drv), 32'd0);
    out_en_n = 1'b0; #1;
    check("R10 async on", 32'(rdata), 32'(model[42]));
  endtask

  task automatic t_sleep();
    read_one(6'd43, "R12 start");
    idle(); sleep = 1'b1; ld_sec_n = 1'b0; addr = 6'd44; wr_all_n = 1'b0;
    wdata = 18'h3FFFF; tick();
    check("R12 released", 32'(rdata_drv), 32'd0);
    idle(); sleep = 1'b1; step_n = 1'b0; tick();
    sleep = 1'b0; step_n = 1'b1; #1;
    check("R12 state kept", 32'(rdata), 32'(model[43]));
    read_one(6'd44, "R12 no write");
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill();
    t_lanes();
    t_step_hold();
    t_priority();
    t_pri_ignored();
    t_deselect();
    t_oe();
    t_sleep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule